// File: doc/BRIEF.md
# Dual-Port Host/Device Mailbox Register File

This block is a small shared register file that two bus masters reach at the same time through their own Wishbone-style slave ports. One port belongs to a host and the other to on-chip device logic. Eight byte-wide locations are shared. They are a control byte that only the host can write, a flag byte, a general value byte, a switch/LED location and four seven-segment digit bytes.

The host uses the flag byte to signal the device. A host write sets the bits written as one. The device acknowledges them by writing ones, which clears those bits. An interrupt-style output stays high while any flag is set. The control byte drives a reset line into the device logic and a select that says which side owns an external memory. The LED and segment bytes are driven straight to pins. Segments are active-low, with bit k (k = 0..6) driving segment a..g and bit 7 driving the decimal point.

Each port takes a request while cyc and stb are both high. It returns one ack pulse on the next cycle, with the read data registered at the moment the request was taken. If both ports write the same location in one cycle, a fixed priority decides the result.

Top module: `mbox_regs`

## Requirements
- R1: Each port raises ack for exactly one cycle, in the cycle after it first samples cyc and stb high together, and gives no further ack until cyc or stb has been low for at least one clock edge.
- R2: After reset, dev_rst_o, host_mem_o, irq_o and led_o are 0, every bit of seg_o is 1, and addresses 0, 1 and 2 read back 0.
- R3: Address 0 is control. A host write stores bit 7 on dev_rst_o and bit 6 on host_mem_o (1 = host owns memory). A read returns those two bits in positions 7 and 6, with bits 5..0 as zero. Device-port writes to address 0 leave it unchanged.
- R4: Address 1 holds eight flags. A host write sets each bit written as 1, a device write clears each bit written as 1, bits written as 0 keep their value, and both ports read the current flags.
- R5: irq_o is high exactly when at least one flag bit is set.
- R6: When the host sets and the device clears the same flag bit in one cycle, the bit ends up set.
- R7: Address 2 is a byte that either port may write and that both ports read back.
- R8: A read of address 3 returns sw_i as sampled on the clock edge that takes the request. A write to address 3 from either port updates led_o.
- R9: Addresses 4 to 7 hold digits 0 to 3. Digit k appears on seg_o[8k+7:8k], digit 0 being the rightmost, and each digit reads back what was last written to it.
- R10: When both ports write the same address among 2 to 7 in one cycle, the device-port data is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| h_cyc_i | input | 1 | Host bus cycle |
| h_stb_i | input | 1 | Host strobe |
| h_we_i | input | 1 | Host write enable |
| h_adr_i | input | 3 | Host register address |
| h_dat_i | input | 8 | Host write data |
| h_dat_o | output | 8 | Host read data |
| h_ack_o | output | 1 | Host acknowledge |
| d_cyc_i | input | 1 | Device bus cycle |
| d_stb_i | input | 1 | Device strobe |
| d_we_i | input | 1 | Device write enable |
| d_adr_i | input | 3 | Device register address |
| d_dat_i | input | 8 | Device write data |
| d_dat_o | output | 8 | Device read data |
| d_ack_o | output | 1 | Device acknowledge |
| sw_i | input | 8 | Switch inputs |
| led_o | output | 8 | LED outputs |
| seg_o | output | 32 | Four active-low segment digits, digit 0 in the low byte |
| dev_rst_o | output | 1 | Reset to device logic, active high |
| host_mem_o | output | 1 | Memory ownership, 1 = host |
| irq_o | output | 1 | High while any flag is set |

## Verification
The properties assume that each master holds its address, write enable and data steady from the cycle it raises stb until it sees ack. The ack-based checks look one cycle back at those inputs to find out what was written. They also assume that a master drops stb in its ack cycle and does not start a new request in that same cycle. The bench drives every request on a falling edge, keeps it unchanged through the accepting edge, and releases it on the falling edge where it samples ack. One directed case keeps stb high for several cycles to check that only a single ack comes back.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int AW      = 3;
  localparam int DW      = 8;
  localparam int NDIG    = 4;
  localparam int SEG_W   = NDIG * DW;

  localparam logic [AW-1:0] ADR_CTRL = 3'd0;
  localparam logic [AW-1:0] ADR_FLAG = 3'd1;
  localparam logic [AW-1:0] ADR_VAL  = 3'd2;
  localparam logic [AW-1:0] ADR_IO   = 3'd3;
  localparam logic [AW-1:0] ADR_SEG  = 3'd4;

  // control byte field positions
  localparam int CTRL_RST_BIT = 7;
  localparam int CTRL_MEM_BIT = 6;

  typedef struct packed {
    logic          fire;
    logic          we;
    logic [AW-1:0] adr;
    logic [DW-1:0] dat;
  } bus_req_t;
endpackage

// File: rtl/mbox_port.sv
module mbox_port
  import mbox_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cyc_i,
  input  logic          stb_i,
  input  logic          we_i,
  input  logic [AW-1:0] adr_i,
  input  logic [DW-1:0] dat_i,
  output bus_req_t      req_o,
  output logic          ack_o
);
  logic held_q;
  logic sel;
  logic accept;

  assign sel    = cyc_i & stb_i;
  assign accept = sel & ~held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= 1'b0;
      ack_o  <= 1'b0;
    end else begin
      ack_o <= accept;
      if (accept)   held_q <= 1'b1;
      else if (!sel) held_q <= 1'b0;
    end
  end

  assign req_o.fire = accept;
  assign req_o.we   = we_i;
  assign req_o.adr  = adr_i;
  assign req_o.dat  = dat_i;
endmodule

// File: rtl/mbox_store.sv
module mbox_store
  import mbox_pkg::*;
#(
  parameter int N_DIG = NDIG
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bus_req_t          h_req_i,
  input  bus_req_t          d_req_i,
  input  logic [DW-1:0]     sw_i,
  output logic [1:0]        ctrl_o,
  output logic [DW-1:0]     flags_o,
  output logic [DW-1:0]     val_o,
  output logic [DW-1:0]     led_o,
  output logic [N_DIG*DW-1:0] seg_o,
  output logic [DW-1:0]     h_rdat_o,
  output logic [DW-1:0]     d_rdat_o
);
  logic h_wr, d_wr;
  logic [DW-1:0] set_mask, clr_mask;

  assign h_wr = h_req_i.fire & h_req_i.we;
  assign d_wr = d_req_i.fire & d_req_i.we;

  assign set_mask = (h_wr && h_req_i.adr == ADR_FLAG) ? h_req_i.dat : '0;
  assign clr_mask = (d_wr && d_req_i.adr == ADR_FLAG) ? d_req_i.dat : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o  <= '0;
      flags_o <= '0;
      val_o   <= '0;
      led_o   <= '0;
    end else begin
      // host-only control
      if (h_wr && h_req_i.adr == ADR_CTRL)
        ctrl_o <= {h_req_i.dat[CTRL_RST_BIT], h_req_i.dat[CTRL_MEM_BIT]};
      // set beats clear on the same bit
      flags_o <= (flags_o & ~clr_mask) | set_mask;
      if (d_wr && d_req_i.adr == ADR_VAL)      val_o <= d_req_i.dat;
      else if (h_wr && h_req_i.adr == ADR_VAL) val_o <= h_req_i.dat;
      if (d_wr && d_req_i.adr == ADR_IO)       led_o <= d_req_i.dat;
      else if (h_wr && h_req_i.adr == ADR_IO)  led_o <= h_req_i.dat;
    end
  end

  for (genvar k = 0; k < N_DIG; k++) begin : g_dig
    localparam logic [AW-1:0] DADR = ADR_SEG + AW'(k);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        seg_o[k*DW +: DW] <= '1;
      else if (d_wr && d_req_i.adr == DADR)
        seg_o[k*DW +: DW] <= d_req_i.dat;
      else if (h_wr && h_req_i.adr == DADR)
        seg_o[k*DW +: DW] <= h_req_i.dat;
    end
  end

  function automatic logic [DW-1:0] rd(input logic [AW-1:0] a);
    logic [DW-1:0] r;
    r = '0;
    if (a == ADR_CTRL) begin
      r[CTRL_RST_BIT] = ctrl_o[1];
      r[CTRL_MEM_BIT] = ctrl_o[0];
    end else if (a == ADR_FLAG) r = flags_o;
    else if (a == ADR_VAL)      r = val_o;
    else if (a == ADR_IO)       r = sw_i;
    else begin
      for (int k = 0; k < N_DIG; k++)
        if (a == ADR_SEG + AW'(k)) r = seg_o[k*DW +: DW];
    end
    return r;
  endfunction

  assign h_rdat_o = rd(h_req_i.adr);
  assign d_rdat_o = rd(d_req_i.adr);
endmodule

// File: rtl/mbox_regs.sv
module mbox_regs
  import mbox_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             h_cyc_i,
  input  logic             h_stb_i,
  input  logic             h_we_i,
  input  logic [AW-1:0]    h_adr_i,
  input  logic [DW-1:0]    h_dat_i,
  output logic [DW-1:0]    h_dat_o,
  output logic             h_ack_o,
  input  logic             d_cyc_i,
  input  logic             d_stb_i,
  input  logic             d_we_i,
  input  logic [AW-1:0]    d_adr_i,
  input  logic [DW-1:0]    d_dat_i,
  output logic [DW-1:0]    d_dat_o,
  output logic             d_ack_o,
  input  logic [DW-1:0]    sw_i,
  output logic [DW-1:0]    led_o,
  output logic [SEG_W-1:0] seg_o,
  output logic             dev_rst_o,
  output logic             host_mem_o,
  output logic             irq_o
);
  bus_req_t      h_req, d_req;
  logic [1:0]    ctrl_q;
  logic [DW-1:0] flags_q, val_q;
  logic [DW-1:0] h_rdat, d_rdat;

  mbox_port u_hport (
    .clk_i, .rst_ni,
    .cyc_i(h_cyc_i), .stb_i(h_stb_i), .we_i(h_we_i),
    .adr_i(h_adr_i), .dat_i(h_dat_i),
    .req_o(h_req), .ack_o(h_ack_o)
  );

  mbox_port u_dport (
    .clk_i, .rst_ni,
    .cyc_i(d_cyc_i), .stb_i(d_stb_i), .we_i(d_we_i),
    .adr_i(d_adr_i), .dat_i(d_dat_i),
    .req_o(d_req), .ack_o(d_ack_o)
  );

  mbox_store #(.N_DIG(NDIG)) u_store (
    .clk_i, .rst_ni,
    .h_req_i(h_req), .d_req_i(d_req), .sw_i,
    .ctrl_o(ctrl_q), .flags_o(flags_q), .val_o(val_q),
    .led_o, .seg_o,
    .h_rdat_o(h_rdat), .d_rdat_o(d_rdat)
  );

  // read data captured on the accepting edge (pre-write view)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_dat_o <= '0;
      d_dat_o <= '0;
    end else begin
      if (h_req.fire) h_dat_o <= h_rdat;
      if (d_req.fire) d_dat_o <= d_rdat;
    end
  end

  assign dev_rst_o  = ctrl_q[1];
  assign host_mem_o = ctrl_q[0];
  assign irq_o      = |flags_q;

  logic unused_val;
  assign unused_val = ^val_q;
endmodule

// File: rtl/mbox_regs_chk.sv
module mbox_regs_chk
  import mbox_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          h_cyc_i,
  input logic          h_stb_i,
  input logic          h_we_i,
  input logic [AW-1:0] h_adr_i,
  input logic [DW-1:0] h_dat_i,
  input logic          h_ack_o,
  input logic          d_cyc_i,
  input logic          d_stb_i,
  input logic          d_we_i,
  input logic [AW-1:0] d_adr_i,
  input logic [DW-1:0] d_dat_i,
  input logic          d_ack_o,
  input logic [DW-1:0] led_o,
  input logic          dev_rst_o,
  input logic          host_mem_o,
  input logic          irq_o,
  input logic [DW-1:0] flags_q
);
  p_h_ack_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_ack_o |=> !h_ack_o);
  p_d_ack_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_ack_o |=> !d_ack_o);
  p_h_ack_cause_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_ack_o |-> $past(h_cyc_i && h_stb_i));
  p_d_ack_cause_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_ack_o |-> $past(d_cyc_i && d_stb_i));

  p_ctrl_dev_ro_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_ack_o && $past(d_we_i && d_adr_i == ADR_CTRL) &&
     !(h_ack_o && $past(h_we_i && h_adr_i == ADR_CTRL)))
    |-> ($stable(dev_rst_o) && $stable(host_mem_o)));

  p_flag_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_ack_o && $past(d_we_i && d_adr_i == ADR_FLAG) &&
     !(h_ack_o && $past(h_we_i && h_adr_i == ADR_FLAG)))
    |-> ((flags_q & $past(d_dat_i)) == '0));

  p_irq_on_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_ack_o && $past(h_we_i && h_adr_i == ADR_FLAG && h_dat_i != '0)) |-> irq_o);

  p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_ack_o && $past(h_we_i && h_adr_i == ADR_FLAG))
    |-> ((flags_q & $past(h_dat_i)) == $past(h_dat_i)));

  p_dev_led_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_ack_o && $past(d_we_i && d_adr_i == ADR_IO)) |-> (led_o == $past(d_dat_i)));
endmodule

bind mbox_regs mbox_regs_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .h_cyc_i(h_cyc_i), .h_stb_i(h_stb_i), .h_we_i(h_we_i),
  .h_adr_i(h_adr_i), .h_dat_i(h_dat_i), .h_ack_o(h_ack_o),
  .d_cyc_i(d_cyc_i), .d_stb_i(d_stb_i), .d_we_i(d_we_i),
  .d_adr_i(d_adr_i), .d_dat_i(d_dat_i), .d_ack_o(d_ack_o),
  .led_o(led_o), .dev_rst_o(dev_rst_o), .host_mem_o(host_mem_o),
  .irq_o(irq_o), .flags_q(flags_q)
);

// File: tb/mbox_regs_tb_top.sv
`timescale 1ns/1ps
module mbox_regs_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       h_cyc = 0, h_stb = 0, h_we = 0;
  logic [2:0] h_adr = 0;
  logic [7:0] h_wdat = 0;
  logic [7:0] h_rdat;
  logic       h_ack;
  logic       d_cyc = 0, d_stb = 0, d_we = 0;
  logic [2:0] d_adr = 0;
  logic [7:0] d_wdat = 0;
  logic [7:0] d_rdat;
  logic       d_ack;
  logic [7:0] sw = 0;
  logic [7:0] led;
  logic [31:0] seg;
  logic dev_rst, host_mem, irq;

  mbox_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .h_cyc_i(h_cyc), .h_stb_i(h_stb), .h_we_i(h_we), .h_adr_i(h_adr),
    .h_dat_i(h_wdat), .h_dat_o(h_rdat), .h_ack_o(h_ack),
    .d_cyc_i(d_cyc), .d_stb_i(d_stb), .d_we_i(d_we), .d_adr_i(d_adr),
    .d_dat_i(d_wdat), .d_dat_o(d_rdat), .d_ack_o(d_ack),
    .sw_i(sw), .led_o(led), .seg_o(seg),
    .dev_rst_o(dev_rst), .host_mem_o(host_mem), .irq_o(irq)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // reference model
  logic [1:0] m_ctrl;
  logic [7:0] m_flag, m_val, m_led;
  logic [31:0] m_seg;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(logic [2:0] a);
    case (a)
      3'd0: return {m_ctrl, 6'b0};
      3'd1: return m_flag;
      3'd2: return m_val;
      3'd3: return sw;
      default: return m_seg[(a-4)*8 +: 8];
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] a);
    case (a)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R7";
      3'd3: return "R8";
      default: return "R9";
    endcase
  endfunction

  // apply writes of one cycle; dev = 1 for device port
  task automatic model_write(bit hw, logic [2:0] ha, logic [7:0] hd,
                             bit dw, logic [2:0] da, logic [7:0] dd);
    logic [7:0] setm, clrm;
    setm = (hw && ha == 1) ? hd : 8'h00;
    clrm = (dw && da == 1) ? dd : 8'h00;
    m_flag = (m_flag & ~clrm) | setm;
    if (hw && ha == 0) m_ctrl = hd[7:6];
    if (hw && ha == 2) m_val = hd;
    if (hw && ha == 3) m_led = hd;
    if (hw && ha >= 4) m_seg[(ha-4)*8 +: 8] = hd;
    if (dw && da == 2) m_val = dd;
    if (dw && da == 3) m_led = dd;
    if (dw && da >= 4) m_seg[(da-4)*8 +: 8] = dd;
  endtask

  task automatic chk_outputs();
    chk("R3 dev_rst_o", dev_rst, m_ctrl[1]);
    chk("R3 host_mem_o", host_mem, m_ctrl[0]);
    chk("R5 irq_o", irq, |m_flag);
    chk("R8 led_o", led, m_led);
    chk("R9 seg_o", seg, m_seg);
  endtask

  // one or two simultaneous transfers; starts and ends on a falling edge
  task automatic xfer(bit hon, bit hw, logic [2:0] ha, logic [7:0] hd,
                      bit don, bit dw, logic [2:0] da, logic [7:0] dd);
    logic [7:0] eh, ed;
    h_cyc = hon; h_stb = hon; h_we = hw; h_adr = ha; h_wdat = hd;
    d_cyc = don; d_stb = don; d_we = dw; d_adr = da; d_wdat = dd;
    eh = exp_rd(ha);
    ed = exp_rd(da);
    @(posedge clk);
    @(negedge clk);
    model_write(hon && hw, ha, hd, don && dw, da, dd);
    if (hon) begin
      chk("R1 host ack", h_ack, 1'b1);
      if (!hw) chk({tag_of(ha), " host read"}, h_rdat, eh);
    end
    if (don) begin
      chk("R1 device ack", d_ack, 1'b1);
      if (!dw) chk({tag_of(da), " device read"}, d_rdat, ed);
    end
    h_cyc = 0; h_stb = 0; d_cyc = 0; d_stb = 0;
    @(negedge clk);
    if (hon) chk("R1 host ack drop", h_ack, 1'b0);
    if (don) chk("R1 device ack drop", d_ack, 1'b0);
    chk_outputs();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int acks;
    void'($urandom(32'h5eed_0042));
    m_ctrl = 0; m_flag = 0; m_val = 0; m_led = 0; m_seg = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: reset state
    chk("R2 dev_rst_o", dev_rst, 0);
    chk("R2 host_mem_o", host_mem, 0);
    chk("R2 irq_o", irq, 0);
    chk("R2 led_o", led, 0);
    chk("R2 seg_o", seg, 32'hFFFF_FFFF);
    for (int a = 0; a < 3; a++) xfer(1, 0, 3'(a), 0, 0, 0, 0, 0);

    // R1: stb held for several cycles yields a single ack
    h_cyc = 1; h_stb = 1; h_we = 0; h_adr = 3'd2;
    acks = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (h_ack) acks++;
    end
    h_cyc = 0; h_stb = 0;
    @(negedge clk);
    chk("R1 single ack on long strobe", acks, 1);
    xfer(1, 0, 3'd2, 0, 0, 0, 0, 0);

    // R3: host writes control, device write ignored
    xfer(1, 1, 3'd0, 8'hFF, 0, 0, 0, 0);
    xfer(0, 0, 0, 0, 1, 0, 3'd0, 0);
    xfer(0, 0, 0, 0, 1, 1, 3'd0, 8'h00);
    xfer(1, 0, 3'd0, 0, 0, 0, 0, 0);
    xfer(1, 1, 3'd0, 8'h40, 0, 0, 0, 0);
    xfer(0, 0, 0, 0, 1, 0, 3'd0, 0);

    // R4 / R5: set, partial clear, full clear
    xfer(1, 1, 3'd1, 8'hA5, 0, 0, 0, 0);
    xfer(0, 0, 0, 0, 1, 1, 3'd1, 8'h05);
    xfer(0, 0, 0, 0, 1, 0, 3'd1, 0);
    xfer(1, 1, 3'd1, 8'h00, 0, 0, 0, 0);
    xfer(0, 0, 0, 0, 1, 1, 3'd1, 8'hFF);
    chk("R5 irq low after full clear", irq, 0);

    // R6: set and clear together
    xfer(1, 1, 3'd1, 8'h0F, 1, 1, 3'd1, 8'hFF);
    chk("R6 set wins", irq, 1);
    xfer(1, 0, 3'd1, 0, 0, 0, 0, 0);

    // R8: switch read and LED write
    sw = 8'h3C;
    xfer(0, 0, 0, 0, 1, 0, 3'd3, 0);
    sw = 8'hC3;
    xfer(1, 0, 3'd3, 0, 0, 0, 0, 0);
    xfer(1, 1, 3'd3, 8'h81, 0, 0, 0, 0);

    // R9: each digit lands in its byte
    for (int k = 0; k < 4; k++) xfer(1, 1, 3'(4 + k), 8'(8'h10 * (k + 1) + k), 0, 0, 0, 0);
    chk("R9 digit0 rightmost", seg[7:0], 8'h10);

    // R10: simultaneous writes, device kept
    xfer(1, 1, 3'd2, 8'h11, 1, 1, 3'd2, 8'h22);
    xfer(1, 0, 3'd2, 0, 0, 0, 0, 0);
    xfer(1, 1, 3'd3, 8'h33, 1, 1, 3'd3, 8'h44);
    xfer(1, 1, 3'd6, 8'h55, 1, 1, 3'd6, 8'h66);

    // R7 and mixed random single-port traffic
    for (int i = 0; i < 300; i++) begin
      bit p;
      p = 1'($urandom);
      sw = 8'($urandom);
      if (p) xfer(1, 1'($urandom), 3'($urandom), 8'($urandom), 0, 0, 0, 0);
      else   xfer(0, 0, 0, 0, 1, 1'($urandom), 3'($urandom), 8'($urandom));
    end

    // random simultaneous traffic (R6, R10)
    for (int i = 0; i < 200; i++) begin
      sw = 8'($urandom);
      xfer(1, 1'($urandom), 3'($urandom), 8'($urandom),
           1, 1'($urandom), 3'($urandom), 8'($urandom));
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule